// File: doc/BRIEF.md
# Split-Chain LCD Segment Driver Core

This block is the logic core of a serial-in, parallel-out segment driver for a multiplexed LCD. Forty segment positions are held in two independent 20-stage shift chains. Each chain has its own serial input and its own serial output, and both advance on the falling edge of a shared shift clock. Tying the low chain's serial output to the high chain's serial input makes one 40-stage chain. The high chain's serial output can feed the next identical block, so panels wider than 40 segments can be driven.

A load level copies the chains into a 40-entry latch. While load is high the latch follows the chains, and while load is low it holds its value. Each latched bit is combined with the externally toggled AC frame signal to give a 2-bit drive-level code per segment. Analog switches then use that code to pick one of four supply levels. The block has no duty counter: the controller sets the multiplex duty, anywhere from 1/8 to 1/16, through the timing of the frame signal.

The whole design runs on one fast system clock. The shift clock is synchronized inside the block and its falling edge is detected there.

Top module: `lcd_seg_drv`

## Requirements
- R1: With rst_n low at a clock edge, both chains and the latch are cleared to zero, so each segment code is 01 while frame is 0 and 10 while frame is 1, and both serial outputs read 0.
- R2: The chains move by exactly one position for each falling edge of sclk_in. A rising edge, or a level held on sclk_in, does not move them.
- R3: The low chain takes din_lo into segment position 0 and presents position 19 on dout_lo. In split use it is independent of the high chain.
- R4: The high chain takes din_hi into position 20 and presents position 39 on dout_hi.
- R5: With dout_lo wired to din_hi, 40 bits shifted into din_lo end up with the first bit shifted at position 39 and the last at position 0.
- R6: While load is high, the latch takes the chain contents at every clock edge, so the segment outputs follow the chains one cycle after they change.
- R7: While load is low, the latch and the segment codes hold, whatever shifting takes place.
- R8: Segment n's code seg_code[2n+1:2n] is 11 for latch 1 with frame 1, 00 for latch 1 with frame 0, 10 for latch 0 with frame 1, and 01 for latch 0 with frame 0. The codes stand for the lowest level, the top supply, the lower middle level and the upper middle level.
- R9: A change on frame changes every segment code in the same cycle, with no register in the path.
- R10: After sclk_in falls before clock edge k, the chains and serial outputs change at edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_in | input | 1 | Shift clock; shifting happens on its falling edge |
| din_lo | input | 1 | Serial data into position 0 |
| din_hi | input | 1 | Serial data into position 20 |
| load | input | 1 | High: latch follows the chains; low: latch holds |
| frame | input | 1 | AC frame signal |
| dout_lo | output | 1 | Serial output, position 19 |
| dout_hi | output | 1 | Serial output, position 39, feeds the next block |
| seg_code | output | 80 | Two-bit drive-level code for each of the 40 segments |

## Verification
A falling edge of the shift clock moves the chains and the serial outputs two clock edges later, through a two-stage synchronizer and an edge register. The bench therefore holds each shift-clock level for four cycles. It samples the serial outputs one cycle before and in the cycle of the shift. The latch takes the chains one edge after load rises, so outputs are compared at the falling clock edge after that. Frame feeds the codes with no register in between, so each frame polarity is checked a fraction of a cycle after it is set, before the next clock edge.

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv #(
  parameter int HALF = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_in,
  input  logic                  din_lo,
  input  logic                  din_hi,
  input  logic                  load,
  input  logic                  frame,
  output logic                  dout_lo,
  output logic                  dout_hi,
  output logic [4*HALF-1:0]     seg_code
);
  localparam int NSEG = 2 * HALF;

  logic [2:0]      sck_q;
  logic            fall;
  logic [HALF-1:0] chain_lo, chain_hi;
  logic [NSEG-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sck_q <= '0;
    else        sck_q <= {sck_q[1:0], sclk_in};
  end

  assign fall = sck_q[2] & ~sck_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_lo <= '0;
      chain_hi <= '0;
    end else if (fall) begin
      chain_lo <= {chain_lo[HALF-2:0], din_lo};
      chain_hi <= {chain_hi[HALF-2:0], din_hi};
    end
  end

  assign dout_lo = chain_lo[HALF-1];
  assign dout_hi = chain_hi[HALF-1];

  always_ff @(posedge clk) begin
    if (!rst_n)    latch_q <= '0;
    else if (load) latch_q <= {chain_hi, chain_lo};
  end

  for (genvar n = 0; n < NSEG; n++) begin : g_code
    assign seg_code[2*n+1] = frame;
    assign seg_code[2*n]   = ~(latch_q[n] ^ frame);
  end

  assert_shift_in_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> chain_lo[0] == $past(din_lo));
  assert_shift_out_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> dout_hi == $past(chain_hi[HALF-2]));
  assert_no_fall_no_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(dout_lo) && $stable(dout_hi));
  assert_transparent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> latch_q == $past({chain_hi, chain_lo}));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(latch_q));
endmodule

// File: tb/tb_lcd_seg_drv.sv
module tb_lcd_seg_drv;
  localparam int HALF = 20;
  localparam int NSEG = 2 * HALF;

  logic clk = 0, rst_n = 0, sclk_in = 0, din_lo = 0, din_hi_drv = 0, load = 0, frame = 0;
  logic cascade = 1;
  logic dout_lo, dout_hi, din_hi;
  logic [2*NSEG-1:0] seg_code;
  logic m [NSEG];
  logic lat [NSEG];
  int checks = 0, errors = 0;
  bit done = 0;

  assign din_hi = cascade ? dout_lo : din_hi_drv;

  lcd_seg_drv #(.HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .din_lo(din_lo), .din_hi(din_hi),
    .load(load), .frame(frame), .dout_lo(dout_lo), .dout_hi(dout_hi), .seg_code(seg_code));

  always #2.5 clk = ~clk;

  task automatic chk1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk_codes(string req);
    for (int f = 0; f < 2; f++) begin
      frame = f[0];
      #0.5;
      checks++;
      for (int q = 0; q < NSEG; q++) begin
        logic [1:0] e;
        e = lat[q] ? (f ? 2'b11 : 2'b00) : (f ? 2'b10 : 2'b01);
        if (seg_code[2*q +: 2] !== e) begin
          errors++;
          $display("FAIL %s seg %0d frame %0d actual %b expected %b", req, q, f, seg_code[2*q +: 2], e);
          break;
        end
      end
    end
    frame = 0;
  endtask

  task automatic shift(logic blo, logic bhi);
    logic olo, ohi;
    logic nm [NSEG];
    @(negedge clk);
    din_lo = blo; din_hi_drv = bhi; sclk_in = 1;
    repeat (4) @(negedge clk);
    chk1("R2 rising edge moves nothing (lo)", dout_lo, m[HALF-1]);
    chk1("R2 rising edge moves nothing (hi)", dout_hi, m[NSEG-1]);
    olo = m[HALF-1]; ohi = m[NSEG-1];
    for (int i = HALF - 1; i > 0; i--) begin
      nm[i] = m[i-1]; nm[HALF+i] = m[HALF+i-1];
    end
    nm[0] = blo;
    nm[HALF] = cascade ? m[HALF-1] : bhi;
    sclk_in = 0;
    repeat (2) @(negedge clk);
    chk1("R10 no shift before edge k+2 (lo)", dout_lo, olo);
    chk1("R10 no shift before edge k+2 (hi)", dout_hi, ohi);
    @(negedge clk);
    chk1("R10/R3 lo chain moved at edge k+2", dout_lo, nm[HALF-1]);
    chk1("R10/R4 hi chain moved at edge k+2", dout_hi, nm[NSEG-1]);
    for (int i = 0; i < NSEG; i++) m[i] = nm[i];
    if (load) begin
      @(negedge clk);
      for (int i = 0; i < NSEG; i++) lat[i] = m[i];
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic do_load();
    @(negedge clk);
    load = 1;
    @(negedge clk);
    for (int i = 0; i < NSEG; i++) lat[i] = m[i];
    chk_codes("R6 latch follows chains one cycle after load");
    load = 0;
    @(negedge clk);
  endtask

  function automatic logic pat(int k, int i);
    case (k)
      0: return i[0];
      1: return (i % 7) == 3;
      2: return ((i * 13 + 5) % 11) < 5;
      default: return ~i[1];
    endcase
  endfunction

  initial begin
    for (int i = 0; i < NSEG; i++) begin m[i] = 0; lat[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk1("R1 dout_lo after reset", dout_lo, 1'b0);
    chk1("R1 dout_hi after reset", dout_hi, 1'b0);
    chk_codes("R1/R8 reset codes");

    for (int k = 0; k < 4; k++) begin
      cascade = 1;
      for (int i = 0; i < NSEG; i++) shift(pat(k, i), 1'b0);
      checks++;
      for (int p = 0; p < NSEG; p++)
        if (m[p] !== pat(k, NSEG - 1 - p)) begin
          errors++;
          $display("FAIL R5 model position %0d actual %0b expected %0b", p, m[p], pat(k, NSEG - 1 - p));
        end
      do_load();
      chk_codes("R5/R8/R9 cascaded pattern");
      for (int i = 0; i < 7; i++) shift(~pat(k, i), 1'b1);
      chk_codes("R7 latch holds while shifting with load low");
      do_load();
      chk_codes("R6 reload after further shifting");
    end

    for (int k = 0; k < 4; k++) begin
      cascade = 0;
      for (int i = 0; i < HALF; i++) shift(pat(k, i), pat(k + 1, i + 3));
      do_load();
      chk_codes("R3/R4 split halves independent");
    end

    cascade = 1;
    load = 1;
    for (int i = 0; i < 5; i++) begin
      shift(pat(2, i + 1), 1'b0);
      chk_codes("R6 transparent while load high");
    end
    load = 0;
    @(negedge clk);

    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < NSEG; i++) begin m[i] = 0; lat[i] = 0; end
    chk_codes("R1 reset clears latch");
    do_load();
    chk1("R1 reset clears chains (hi)", dout_hi, 1'b0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule